// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block carries out clean and invalidate maintenance on a physically indexed, physically tagged cache. The cache itself is represented by a small direct-mapped array of valid, dirty and tag state kept inside the block. A fill port installs lines into the array, and a lookup port reports whether an address is present and whether it is dirty.

Range maintenance is armed in two steps. The first command records a start address. A following end command supplies the end address, chooses clean or invalidate, and starts the walk. The engine then visits every line whose base address lies between the start line and the end line, both included. It handles one line per cycle in ascending order and keeps a stall output high for the whole walk. A clean that finds a valid dirty line produces a one-cycle writeback pulse carrying the line address and clears the dirty bit. Single-line clean, invalidate and clean-and-invalidate commands act at once and do not stall.

Only the start address of a range is assumed to have been translated, so a range must stay inside one page. A range whose end falls in another page, or whose end is below its start, touches nothing and pulses an error flag.

Top module: `cache_range_maint`

## Requirements
- R1: After a synchronous active-low reset, stall, err and wb_valid are low and every lookup reports a miss.
- R2: A range is armed by a command with code 1 (record start), followed by code 2 (end and clean) or code 3 (end and invalidate). An end command with no recorded start is ignored. A second code-1 command replaces the recorded start. A trigger consumes the recorded start.
- R3: The walk covers every line from the start line to the end line, both included, in ascending order, one line per cycle. Address bits [4:0] of the 32-byte line are ignored.
- R4: stall is high for exactly N cycles for an N-line range, starting in the cycle after the trigger command.
- R5: A clean of a valid dirty line gives a one-cycle wb_valid with wb_addr equal to the line base address one cycle after the line is processed. The line stays valid and becomes clean. A clean line gives no writeback.
- R6: A range invalidate makes each covered line invalid and gives no writeback, even for dirty lines.
- R7: Code 4 cleans one line, code 5 invalidates one line, and code 6 writes back the line if it is dirty and then invalidates it. Each takes effect at the command edge without raising stall.
- R8: If the start and end addresses differ above the page offset (page size is a parameter, 4 KiB by default), err is high for one cycle after the trigger. No line is touched, stall stays low, and the recorded start is consumed.
- R9: If the end line is below the start line, the block behaves as in R8: a one-cycle err pulse and no line touched.
- R10: A maintenance action on an address whose tag does not match the line stored at its index leaves that line unchanged and gives no writeback.
- R11: Commands presented while stall is high are ignored.
- R12: fill_valid installs the line at fill_addr as valid, with its dirty bit taken from fill_dirty. look_hit and look_dirty report the state for look_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R2, R7) |
| cmd_addr | input | AW | Command byte address |
| fill_valid | input | 1 | Install a line in the array |
| fill_addr | input | AW | Byte address of the line being installed |
| fill_dirty | input | 1 | Dirty state of the installed line |
| look_addr | input | AW | Byte address to look up |
| look_hit | output | 1 | look_addr is present |
| look_dirty | output | 1 | look_addr is present and dirty |
| stall | output | 1 | Range walk in progress; requester must wait |
| err | output | 1 | One-cycle pulse on a rejected range |
| wb_valid | output | 1 | One-cycle writeback request |
| wb_addr | output | AW | Line base address of the writeback |

## Verification
A wrong walk pointer shows up one cycle after the bad line is processed. It appears as a writeback with an unexpected address, or as a missing or extra writeback. Each writeback is compared in order against a queue of predicted addresses. A stale pending start, or a page or order check that passes when it should fail, changes how many cycles stall stays high, or whether err pulses in the cycle right after the trigger. Corrupted valid or dirty state does not show up until the line is looked up, so the lookup port is read after every operation, on the lines at both ends of each range and just outside it.

// File: rtl/cmaint_pkg.sv
// Shared command encoding for the cache range maintenance engine.
package cmaint_pkg;
    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_SET_START  = 3'd1,
        OP_END_CLEAN  = 3'd2,
        OP_END_INV    = 3'd3,
        OP_LINE_CLEAN = 3'd4,
        OP_LINE_INV   = 3'd5,
        OP_LINE_CLINV = 3'd6
    } cm_op_e;
endpackage

// File: rtl/cmaint_tag_array.sv
// Direct-mapped valid/dirty/tag store standing in for the cache.
// Applies one maintenance action per cycle, accepts fills, and gives a
// combinational lookup. Assumes that when a fill and an action hit the same
// index in the same cycle, the action's state update wins.
module cmaint_tag_array #(
    parameter int AW   = 32,
    parameter int OFF  = 5,
    parameter int IDXW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  logic             act_clean,
    input  logic             act_inv,
    input  logic [AW-OFF-1:0] act_line,
    input  logic             fill_valid,
    input  logic [AW-OFF-1:0] fill_line,
    input  logic             fill_dirty,
    input  logic [AW-OFF-1:0] look_line,
    output logic             look_hit,
    output logic             look_dirty,
    output logic             wb_valid,
    output logic [AW-1:0]    wb_addr
);
    localparam int LW = AW - OFF;
    localparam int TW = LW - IDXW;
    localparam int NS = 1 << IDXW;

    logic          valid_q [NS];
    logic          dirty_q [NS];
    logic [TW-1:0] tag_q   [NS];

    logic [IDXW-1:0] act_idx, fill_idx, look_idx;
    logic            act_hit;

    // Split line numbers into index and tag.
    always_comb begin
        act_idx  = act_line[IDXW-1:0];
        fill_idx = fill_line[IDXW-1:0];
        look_idx = look_line[IDXW-1:0];
        act_hit  = valid_q[act_idx] && (tag_q[act_idx] == act_line[LW-1:IDXW]);
        look_hit   = valid_q[look_idx] && (tag_q[look_idx] == look_line[LW-1:IDXW]);
        look_dirty = look_hit && dirty_q[look_idx];
    end

    // Valid and dirty state: fills first, then maintenance actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
            end
        end else begin
            if (fill_valid) begin
                valid_q[fill_idx] <= 1'b1;
                dirty_q[fill_idx] <= fill_dirty;
            end
            if (act_valid && act_hit) begin
                if (act_clean) dirty_q[act_idx] <= 1'b0;
                if (act_inv) begin
                    valid_q[act_idx] <= 1'b0;
                    dirty_q[act_idx] <= 1'b0;
                end
            end
        end
    end

    // Tag storage, written only by fills.
    always_ff @(posedge clk) begin
        if (fill_valid) tag_q[fill_idx] <= fill_line[LW-1:IDXW];
    end

    // Writeback request for a clean that meets a dirty valid line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
        end else begin
            wb_valid <= act_valid && act_clean && act_hit && dirty_q[act_idx];
            wb_addr  <= {act_line, {OFF{1'b0}}};
        end
    end

    // R5: a writeback only follows a clean action in the previous cycle.
    a_r5_wb_after_clean: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(act_valid && act_clean));

    // R6: an invalidate that hits leaves the line absent from lookup of the same line.
    a_r6_inv_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_inv && act_hit && !fill_valid && look_line == act_line)
        ##1 (look_line == $past(look_line)) |-> !look_hit);
endmodule

// File: rtl/cmaint_range_seq.sv
// Range sequencer: records the start line, checks the end command against
// page and order rules, then walks lines one per cycle in ascending order.
// Single-line commands pass straight through as actions. Commands arriving
// while a walk is active are dropped.
module cmaint_range_seq
    import cmaint_pkg::*;
#(
    parameter int AW  = 32,
    parameter int OFF = 5,
    parameter int PGB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cm_op_e            cmd_op,
    input  logic [AW-OFF-1:0] cmd_line,
    output logic              busy,
    output logic              err,
    output logic              act_valid,
    output logic              act_clean,
    output logic              act_inv,
    output logic [AW-OFF-1:0] act_line
);
    localparam int LW  = AW - OFF;
    localparam int PLW = PGB - OFF;

    logic          pend_q, busy_q, clean_q, err_q;
    logic [LW-1:0] start_q, cur_q, last_q;
    logic          accept, is_end, trig, page_bad, order_bad, go;

    // Decode the incoming command against the recorded start.
    always_comb begin
        accept    = cmd_valid && !busy_q;
        is_end    = (cmd_op == OP_END_CLEAN) || (cmd_op == OP_END_INV);
        trig      = accept && is_end && pend_q;
        page_bad  = start_q[LW-1:PLW] != cmd_line[LW-1:PLW];
        order_bad = cmd_line < start_q;
        go        = trig && !page_bad && !order_bad;
    end

    // Start recording, walk pointer and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            busy_q  <= 1'b0;
            clean_q <= 1'b0;
            err_q   <= 1'b0;
            start_q <= '0;
            cur_q   <= '0;
            last_q  <= '0;
        end else begin
            err_q <= trig && (page_bad || order_bad);
            if (accept && cmd_op == OP_SET_START) begin
                pend_q  <= 1'b1;
                start_q <= cmd_line;
            end else if (trig) begin
                pend_q <= 1'b0;
            end
            if (go) begin
                busy_q  <= 1'b1;
                cur_q   <= start_q;
                last_q  <= cmd_line;
                clean_q <= (cmd_op == OP_END_CLEAN);
            end else if (busy_q) begin
                if (cur_q == last_q) busy_q <= 1'b0;
                else                 cur_q  <= cur_q + 1'b1;
            end
        end
    end

    // Pick the action for this cycle: walk line or single-line command.
    always_comb begin
        act_valid = 1'b0;
        act_clean = 1'b0;
        act_inv   = 1'b0;
        act_line  = cmd_line;
        if (busy_q) begin
            act_valid = 1'b1;
            act_line  = cur_q;
            act_clean = clean_q;
            act_inv   = !clean_q;
        end else if (accept) begin
            act_clean = (cmd_op == OP_LINE_CLEAN) || (cmd_op == OP_LINE_CLINV);
            act_inv   = (cmd_op == OP_LINE_INV)   || (cmd_op == OP_LINE_CLINV);
            act_valid = act_clean || act_inv;
        end
    end

    assign busy = busy_q;
    assign err  = err_q;

    // R4: the walk ends right after its last line.
    a_r4_walk_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cur_q == last_q) |=> !busy_q);

    // R3: consecutive walk cycles visit consecutive lines.
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> (cur_q == $past(cur_q) + 1'b1));

    // R11: nothing is recorded while a walk is active.
    a_r11_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(start_q));

    // R8: a rejected range never starts a walk.
    a_r8_err_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !busy_q);

    // R8: the error flag is a single-cycle pulse.
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);
endmodule

// File: rtl/cache_range_maint.sv
// Top of the cache range maintenance engine. Converts byte addresses to
// line numbers and joins the range sequencer to the tag array model.
// Assumes a power-of-two line size, page size and set count.
module cache_range_maint #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int NSETS      = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic          fill_valid,
    input  logic [AW-1:0] fill_addr,
    input  logic          fill_dirty,
    input  logic [AW-1:0] look_addr,
    output logic          look_hit,
    output logic          look_dirty,
    output logic          stall,
    output logic          err,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr
);
    import cmaint_pkg::*;

    localparam int OFF  = $clog2(LINE_BYTES);
    localparam int PGB  = $clog2(PAGE_BYTES);
    localparam int IDXW = $clog2(NSETS);
    localparam int LW   = AW - OFF;

    logic          act_valid, act_clean, act_inv;
    logic [LW-1:0] act_line;

    cmaint_range_seq #(.AW(AW), .OFF(OFF), .PGB(PGB)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cm_op_e'(cmd_op)),
        .cmd_line  (cmd_addr[AW-1:OFF]),
        .busy      (stall),
        .err       (err),
        .act_valid (act_valid),
        .act_clean (act_clean),
        .act_inv   (act_inv),
        .act_line  (act_line)
    );

    cmaint_tag_array #(.AW(AW), .OFF(OFF), .IDXW(IDXW)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_valid  (act_valid),
        .act_clean  (act_clean),
        .act_inv    (act_inv),
        .act_line   (act_line),
        .fill_valid (fill_valid),
        .fill_line  (fill_addr[AW-1:OFF]),
        .fill_dirty (fill_dirty),
        .look_line  (look_addr[AW-1:OFF]),
        .look_hit   (look_hit),
        .look_dirty (look_dirty),
        .wb_valid   (wb_valid),
        .wb_addr    (wb_addr)
    );

    // R4: stall only rises after a command was presented.
    a_r4_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(cmd_valid));

    // R5: writeback addresses are always line aligned.
    a_r5_wb_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_addr[OFF-1:0] == '0));
endmodule

// File: tb/sim_cache_range_maint.sv
// Scoreboard bench: stimulus tasks push predicted writeback addresses into
// a queue; a negedge monitor pops and compares each writeback as it appears.
module sim_cache_range_maint;
    localparam int CLK_NS = 10;
    localparam logic [31:0] BASE = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] cmd_addr = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        fill_dirty = 1'b0;
    logic [31:0] look_addr = '0;
    logic        look_hit, look_dirty, stall, err, wb_valid;
    logic [31:0] wb_addr;

    int compared = 0;
    int mismatched = 0;
    logic [31:0] exp_q[$];

    cache_range_maint u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_dirty(fill_dirty), .look_addr(look_addr), .look_hit(look_hit),
        .look_dirty(look_dirty), .stall(stall), .err(err),
        .wb_valid(wb_valid), .wb_addr(wb_addr)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [31:0] ln(input int i);
        return BASE + 32'(i) * 32'd32;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: each writeback must match the oldest predicted address.
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            if (exp_q.size() == 0) chk("R5 unexpected writeback", {32'd0, wb_addr}, 64'hFFFF_FFFF);
            else chk("R5 writeback address", {32'd0, wb_addr}, {32'd0, exp_q.pop_front()});
        end
    end

    task automatic fill(input logic [31:0] a, input logic d);
        fill_valid = 1'b1; fill_addr = a; fill_dirty = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] op, input logic [31:0] a);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    // Count cycles with stall high, starting at the negedge after a trigger.
    task automatic count_stall(output int n);
        n = 0;
        while (stall && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic look(input string req, input logic [31:0] a, input logic h, input logic d);
        look_addr = a;
        #1;
        chk(req, {62'd0, look_hit, look_dirty}, {62'd0, h, d});
    endtask

    initial begin
        #(CLK_NS * 100000);
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 stall", {63'd0, stall}, 0);
        chk("R1 err", {63'd0, err}, 0);
        chk("R1 wb_valid", {63'd0, wb_valid}, 0);
        look("R1 lookup miss", ln(0), 0, 0);

        // R12: fill lines 0..15, even ones dirty
        for (int i = 0; i < 16; i++) fill(ln(i), (i % 2) == 0);
        look("R12 dirty fill", ln(2), 1, 1);
        look("R12 clean fill", ln(3), 1, 0);

        // R2 R3 R4 R5: clean range lines 1..6, offset bits set
        exp_q.push_back(ln(2)); exp_q.push_back(ln(4)); exp_q.push_back(ln(6));
        cmd(3'd1, ln(1) + 32'd5);
        cmd(3'd2, ln(6) + 32'h1F);
        count_stall(n);
        chk("R4 stall cycles 6 lines", 64'(n), 6);
        @(negedge clk);
        look("R5 cleaned stays valid", ln(2), 1, 0);
        look("R3 end line included", ln(6), 1, 0);
        look("R3 before start untouched", ln(0), 1, 1);
        look("R3 after end untouched", ln(8), 1, 1);

        // R6: invalidate range lines 8..10
        cmd(3'd1, ln(8));
        cmd(3'd3, ln(10));
        count_stall(n);
        chk("R6 stall cycles 3 lines", 64'(n), 3);
        look("R6 first invalid", ln(8), 0, 0);
        look("R6 last invalid", ln(10), 0, 0);
        look("R6 next untouched", ln(11), 1, 0);

        // R7: single-line commands
        exp_q.push_back(ln(12));
        cmd(3'd4, ln(12));
        chk("R7 no stall on line op", {63'd0, stall}, 0);
        @(negedge clk);
        look("R7 line clean", ln(12), 1, 0);
        cmd(3'd5, ln(14));
        look("R7 line invalidate", ln(14), 0, 0);
        exp_q.push_back(ln(0));
        cmd(3'd6, ln(0));
        @(negedge clk);
        look("R7 clean-invalidate", ln(0), 0, 0);

        // R10: alias address with a different tag
        fill(ln(3), 1'b1);
        cmd(3'd5, ln(3 + 64));
        cmd(3'd4, ln(3 + 64));
        @(negedge clk);
        look("R10 alias leaves line", ln(3), 1, 1);

        // R8: page crossing
        fill(ln(127), 1'b1);
        cmd(3'd1, ln(127));
        cmd(3'd2, BASE + 32'h1000);
        chk("R8 err pulse", {63'd0, err}, 1);
        chk("R8 no stall", {63'd0, stall}, 0);
        @(negedge clk);
        chk("R8 err one cycle", {63'd0, err}, 0);
        look("R8 line untouched", ln(127), 1, 1);

        // R9: end below start
        cmd(3'd1, ln(5));
        cmd(3'd3, ln(1));
        chk("R9 err pulse", {63'd0, err}, 1);
        chk("R9 no stall", {63'd0, stall}, 0);
        look("R9 lines untouched", ln(1), 1, 0);

        // R2: end with no recorded start is ignored
        cmd(3'd3, ln(1));
        chk("R2 lone end no err", {63'd0, err}, 0);
        chk("R2 lone end no stall", {63'd0, stall}, 0);
        look("R2 lone end untouched", ln(1), 1, 0);

        // R2: second start replaces the first
        exp_q.push_back(ln(3));
        cmd(3'd1, ln(1));
        cmd(3'd1, ln(3));
        cmd(3'd2, ln(3));
        count_stall(n);
        chk("R2 replaced start one line", 64'(n), 1);
        look("R2 replaced start cleaned", ln(3), 1, 0);

        // R11: command during a walk is ignored
        for (int i = 16; i < 25; i++) fill(ln(i), 1'b1);
        for (int i = 16; i < 24; i++) exp_q.push_back(ln(i));
        cmd(3'd1, ln(16));
        cmd(3'd2, ln(23));
        cmd(3'd5, ln(24));
        count_stall(n);
        chk("R11 walk length", 64'(n + 1), 8);
        look("R11 dropped command", ln(24), 1, 1);

        // R3: last lines of a page
        fill(ln(126), 1'b1);
        exp_q.push_back(ln(126)); exp_q.push_back(ln(127));
        cmd(3'd1, ln(126));
        cmd(3'd2, ln(127));
        count_stall(n);
        chk("R3 page tail 2 lines", 64'(n), 2);

        // R3 R6: one-line range
        cmd(3'd1, ln(11));
        cmd(3'd3, ln(11));
        count_stall(n);
        chk("R4 single line range", 64'(n), 1);
        look("R6 single invalid", ln(11), 0, 0);
        look("R6 neighbour kept", ln(12), 1, 0);

        repeat (3) @(negedge clk);
        chk("R5 all writebacks seen", 64'(exp_q.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule